// File: doc/BRIEF.md
# UART Register Front End

This block is the software-facing register file of a simple serial port. A host issues single-byte reads and writes on a 6-bit offset bus. The block holds the port's mode bytes, status, interrupt flags and mask. It decodes packed command bytes into receiver, transmitter and housekeeping actions. It passes one transmit byte at a time to a downstream serializer through a valid/ready handshake, pops bytes from a separate receive FIFO, and drives one level-sensitive interrupt line.

Two mode bytes share offset 0x00. A 1-bit pointer chooses between them and advances on its own after each write. The receive interrupt source is chosen by a mode bit: it is either "data available" or "FIFO full". Read data is combinational and valid in the same cycle as the request. The interrupt output is registered, so it lags the interrupt flags by one clock.

Top module: `uart_csr_top`

## Requirements
- R1: After reset, status (offset 0x04) reads 0x08, interrupt flags (0x14) read 0x00, offset 0x00 reads 0x00, and irq_o is low.
- R2: A write to 0x00 goes to the mode byte chosen by the pointer, then points at the second byte. Later writes keep going to the second byte. Reads of 0x00 return the chosen byte. A command whose bits 6:4 equal 1 points back at the first byte.
- R3: Writes to 0x04 change nothing. Offsets 0x10, 0x3C and any other unmapped offset read 0x00.
- R4: Command bits 3:2 drive the transmitter enable: 1 sets it, 2 clears it, 0 and 3 leave it unchanged. Status bit2 equals the enable from the cycle after the write.
- R5: Command bits 1:0 drive rx_en_o with the same encoding as R4.
- R6: A write to 0x0C stores the byte and clears status bit3. tx_valid_o is high only while a byte is pending and the transmitter is enabled. Status bit3 sets again on the clock of the accepting handshake.
- R7: A data write in the same cycle as a handshake keeps the new byte pending, so every written byte is presented in write order.
- R8: Command bits 6:4 equal to 2 clear the receiver enable and pulse rx_flush_o for one cycle. A receiver field of 1 in the same byte is applied afterwards and leaves reception enabled.
- R9: Command bits 6:4 equal to 3 drop any pending byte, clear the transmitter enable and set status bit3. A transmitter field of 1 in the same byte re-enables it.
- R10: A read of 0x0C returns rx_data_i and asserts rx_pop_o when the FIFO is not empty. When the FIFO is empty it returns 0x00 and does not pop.
- R11: Status bit0 is the inverse of rx_empty_i, bit1 is rx_full_i, and bits 7:4 are rx_err_i.
- R12: Interrupt flag bit0 is status bit2. Flag bit1 is status bit1 when bit6 of the first mode byte is set, and status bit0 otherwise. Flag bit2 is set by rx_break_i and cleared by command code 5 in bits 6:4; if both happen in the same cycle, the set wins. Bits 7:3 read 0.
- R13: A write to 0x14 loads the mask. irq_o equals the OR of flags AND mask, delayed by one clock.
- R14: Offsets 0x18 and 0x1C return the parameters BAUD_LO and BAUD_HI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, same cycle |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_ready_i | input | 1 | Serializer takes the byte |
| tx_data_o | output | 8 | Transmit byte |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_data_i | input | 8 | Receive FIFO head byte |
| rx_err_i | input | 4 | Receive error flags for status 7:4 |
| rx_break_i | input | 1 | Break-detected pulse |
| rx_pop_o | output | 1 | Pop the receive FIFO |
| rx_flush_o | output | 1 | Empty the receive FIFO |
| rx_en_o | output | 1 | Receiver enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can land in the same cycle. The first is a host write of a new transmit byte while the serializer accepts the previous one. The bench holds tx_ready_i high and writes two bytes back to back. The scoreboard checks that both bytes appear at the handshake in write order and that the transmitter-empty flag stays clear until the second byte has gone. The second is a break pulse arriving together with the break-clear command. The bench drives both in one cycle and expects the flag to remain set.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] OFF_MODE    = 6'h00;
  localparam logic [AW-1:0] OFF_STAT    = 6'h04;
  localparam logic [AW-1:0] OFF_CMD     = 6'h08;
  localparam logic [AW-1:0] OFF_DATA    = 6'h0C;
  localparam logic [AW-1:0] OFF_INT     = 6'h14;
  localparam logic [AW-1:0] OFF_BAUD_LO = 6'h18;
  localparam logic [AW-1:0] OFF_BAUD_HI = 6'h1C;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_RST = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_RST = 3'd4,
    MISC_BRK_CLR = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_e;

  typedef enum logic [1:0] {
    EN_NOP  = 2'd0,
    EN_ON   = 2'd1,
    EN_OFF  = 2'd2,
    EN_RSVD = 2'd3
  } en_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
    logic rx_set;
    logic rx_clr;
    logic tx_set;
    logic tx_clr;
  } cmd_act_t;
endpackage

// File: rtl/uart_csr_cmd_dec.sv
module uart_csr_cmd_dec
  import uart_csr_pkg::*;
(
  input  logic       cmd_we_i,
  input  logic [6:0] cmd_i,
  output cmd_act_t   act_o
);
  misc_e misc;
  en_e   tx_code;
  en_e   rx_code;

  assign misc    = misc_e'(cmd_i[6:4]);
  assign tx_code = en_e'(cmd_i[3:2]);
  assign rx_code = en_e'(cmd_i[1:0]);

  always_comb begin
    act_o = '0;
    if (cmd_we_i) begin
      unique case (misc)
        MISC_PTR_RST: act_o.ptr_rst = 1'b1;
        MISC_RX_RST:  act_o.rx_rst  = 1'b1;
        MISC_TX_RST:  act_o.tx_rst  = 1'b1;
        MISC_BRK_CLR: act_o.brk_clr = 1'b1;
        default: ;
      endcase
      act_o.tx_set = (tx_code == EN_ON);
      act_o.tx_clr = (tx_code == EN_OFF);
      act_o.rx_set = (rx_code == EN_ON);
      act_o.rx_clr = (rx_code == EN_OFF);
    end
  end
endmodule

// File: rtl/uart_csr_mode.sv
module uart_csr_mode
  import uart_csr_pkg::*;
#(
  parameter int unsigned MODE_N     = 2,
  parameter int unsigned RX_SEL_BIT = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ptr_rst_i,
  output logic [DW-1:0] mode_o,
  output logic          rx_sel_full_o
);
  localparam int unsigned PTR_W = (MODE_N > 1) ? $clog2(MODE_N) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MODE_N - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [DW-1:0]    mr_q [MODE_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ptr_rst_i) begin
      ptr_q <= '0;
    end else if (wr_i && ptr_q != PTR_LAST) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < MODE_N; g++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mr_q[g] <= '0;
      else if (wr_i && ptr_q == PTR_W'(g))   mr_q[g] <= wdata_i;
    end
  end

  assign mode_o        = mr_q[ptr_q];
  assign rx_sel_full_o = mr_q[0][RX_SEL_BIT];
endmodule

// File: rtl/uart_csr_tx.sv
module uart_csr_tx
  import uart_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_rst_i,
  input  logic          tx_set_i,
  input  logic          tx_clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tx_ready_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_en_o,
  output logic          tx_empty_o
);
  logic          en_q, pend_q;
  logic [DW-1:0] data_q;
  logic          beat;

  assign tx_valid_o = pend_q & en_q;
  assign beat       = tx_valid_o & tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      // misc reset first, then the enable field of the same command
      if (tx_rst_i)      en_q <= tx_set_i;
      else if (tx_set_i) en_q <= 1'b1;
      else if (tx_clr_i) en_q <= 1'b0;

      if (wr_i) begin
        pend_q <= 1'b1;
        data_q <= wdata_i;
      end else if (tx_rst_i || beat) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign tx_data_o  = data_q;
  assign tx_en_o    = en_q;
  assign tx_empty_o = ~pend_q;
endmodule

// File: rtl/uart_csr_irq.sv
module uart_csr_irq
  import uart_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_rdy_i,
  input  logic          rx_rdy_i,
  input  logic          rx_full_i,
  input  logic          sel_full_i,
  input  logic          brk_set_i,
  input  logic          brk_clr_i,
  input  logic          imr_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] isr_o,
  output logic [DW-1:0] imr_o,
  output logic          irq_o
);
  logic          brk_q, irq_q;
  logic [DW-1:0] imr_q;

  assign isr_o = {{(DW-3){1'b0}}, brk_q, (sel_full_i ? rx_full_i : rx_rdy_i), tx_rdy_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q <= 1'b0;
      imr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (brk_set_i)      brk_q <= 1'b1;
      else if (brk_clr_i) brk_q <= 1'b0;
      if (imr_we_i) imr_q <= wdata_i;
      irq_q <= |(isr_o & imr_q);
    end
  end

  assign imr_o = imr_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/uart_csr_top.sv
module uart_csr_top
  import uart_csr_pkg::*;
#(
  parameter logic [7:0]  BAUD_LO    = 8'h00,
  parameter logic [7:0]  BAUD_HI    = 8'h00,
  parameter int unsigned RX_SEL_BIT = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [5:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic [7:0] tx_data_o,
  input  logic       rx_empty_i,
  input  logic       rx_full_i,
  input  logic [7:0] rx_data_i,
  input  logic [3:0] rx_err_i,
  input  logic       rx_break_i,
  output logic       rx_pop_o,
  output logic       rx_flush_o,
  output logic       rx_en_o,
  output logic       irq_o
);
  logic          wr, rd;
  cmd_act_t      act;
  logic [DW-1:0] mode_rd, isr_w, imr_w, status;
  logic          sel_full, tx_en, tx_empty, rx_en_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  uart_csr_cmd_dec u_cmd (
    .cmd_we_i (wr && addr_i == OFF_CMD),
    .cmd_i    (wdata_i[6:0]),
    .act_o    (act)
  );

  uart_csr_mode #(.MODE_N(2), .RX_SEL_BIT(RX_SEL_BIT)) u_mode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr && addr_i == OFF_MODE),
    .wdata_i       (wdata_i),
    .ptr_rst_i     (act.ptr_rst),
    .mode_o        (mode_rd),
    .rx_sel_full_o (sel_full)
  );

  uart_csr_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_rst_i   (act.tx_rst),
    .tx_set_i   (act.tx_set),
    .tx_clr_i   (act.tx_clr),
    .wr_i       (wr && addr_i == OFF_DATA),
    .wdata_i    (wdata_i),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_en_o    (tx_en),
    .tx_empty_o (tx_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rx_en_q <= 1'b0;
    else if (act.rx_set)    rx_en_q <= 1'b1;
    else if (act.rx_rst || act.rx_clr) rx_en_q <= 1'b0;
  end

  assign status = {rx_err_i, tx_empty, tx_en, rx_full_i, ~rx_empty_i};

  uart_csr_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_rdy_i   (tx_en),
    .rx_rdy_i   (~rx_empty_i),
    .rx_full_i  (rx_full_i),
    .sel_full_i (sel_full),
    .brk_set_i  (rx_break_i),
    .brk_clr_i  (act.brk_clr),
    .imr_we_i   (wr && addr_i == OFF_INT),
    .wdata_i    (wdata_i),
    .isr_o      (isr_w),
    .imr_o      (imr_w),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFF_MODE:    rdata_o = mode_rd;
        OFF_STAT:    rdata_o = status;
        OFF_DATA:    rdata_o = rx_empty_i ? '0 : rx_data_i;
        OFF_INT:     rdata_o = isr_w;
        OFF_BAUD_LO: rdata_o = BAUD_LO;
        OFF_BAUD_HI: rdata_o = BAUD_HI;
        default:     rdata_o = '0;
      endcase
    end
  end

  assign rx_pop_o   = rd && addr_i == OFF_DATA && !rx_empty_i;
  assign rx_flush_o = act.rx_rst;
  assign rx_en_o    = rx_en_q;
endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk
  import uart_csr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [5:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       rx_empty_i,
  input logic       rx_pop_o,
  input logic       rx_en_o,
  input logic       irq_o,
  input logic [7:0] isr_i,
  input logic [7:0] imr_i
);
  logic cmd_wr;
  assign cmd_wr = req_i && we_i && addr_i == OFF_CMD;

  a_r13_irq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(isr_i & imr_i)));

  a_r10_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> !rx_empty_i);

  a_r6_hold_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !(req_i && we_i && (addr_i == OFF_DATA || addr_i == OFF_CMD)))
    |=> (tx_valid_o && $stable(tx_data_o)));

  a_r9_tx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[6:4] == 3'd3 && wdata_i[3:2] != 2'd1) |=> !tx_valid_o);

  a_r8_rx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[6:4] == 3'd2 && wdata_i[1:0] != 2'd1) |=> !rx_en_o);
endmodule

bind uart_csr_top uart_csr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .rx_empty_i (rx_empty_i),
  .rx_pop_o   (rx_pop_o),
  .rx_en_o    (rx_en_o),
  .irq_o      (irq_o),
  .isr_i      (isr_w),
  .imr_i      (imr_w)
);

// File: tb/uart_csr_top_tb.sv
module uart_csr_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       rx_empty = 1'b1, rx_full = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [3:0] rx_err = 4'h0;
  logic       rx_break = 1'b0;
  logic       rx_pop, rx_flush, rx_en, irq;

  int errors = 0, checks = 0;
  int pops = 0, flushes = 0, tx_beats = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_csr_top #(.BAUD_LO(8'h3C), .BAUD_HI(8'hC3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .tx_data_o(tx_data), .rx_empty_i(rx_empty),
    .rx_full_i(rx_full), .rx_data_i(rx_data), .rx_err_i(rx_err),
    .rx_break_i(rx_break), .rx_pop_o(rx_pop), .rx_flush_o(rx_flush),
    .rx_en_o(rx_en), .irq_o(irq)
  );

  // scoreboard queues
  logic [7:0] rd_exp_q[$];
  string      rd_tag_q[$];
  logic [7:0] tx_exp_q[$];
  event       rd_sample;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // read monitor
  always @(rd_sample) begin
    logic [7:0] e;
    string t;
    e = rd_exp_q.pop_front();
    t = rd_tag_q.pop_front();
    check(t, rdata, e);
  end

  // transmit monitor
  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      tx_beats++;
      if (tx_exp_q.size() == 0) check("R6 unexpected tx beat", tx_data, 8'hxx);
      else check("R7 tx byte order", tx_data, tx_exp_q.pop_front());
    end
    if (rst_n && rx_pop)   pops++;
    if (rst_n && rx_flush) flushes++;
  end

  task automatic rd(logic [5:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    rd_exp_q.push_back(e);
    rd_tag_q.push_back(tag);
    #2 -> rd_sample;
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1 irq after reset", irq, 1'b0);
    rd(6'h04, 8'h08, "R1 status reset");
    rd(6'h14, 8'h00, "R1 isr reset");
    rd(6'h00, 8'h00, "R1 mode reset");

    // R2 mode pointer
    wr(6'h00, 8'h11);
    wr(6'h00, 8'h22);
    wr(6'h00, 8'h33);
    rd(6'h00, 8'h33, "R2 second mode byte");
    wr(6'h08, 8'h10);
    rd(6'h00, 8'h11, "R2 pointer back to first");

    // R3 ignored and unmapped
    wr(6'h04, 8'hFF);
    rd(6'h04, 8'h08, "R3 status write ignored");
    rd(6'h10, 8'h00, "R3 unmapped 0x10");
    rd(6'h3C, 8'h00, "R3 unmapped 0x3C");

    // R14 baud bytes
    rd(6'h18, 8'h3C, "R14 baud low");
    rd(6'h1C, 8'hC3, "R14 baud high");

    // R4 transmitter enable field
    wr(6'h08, 8'h04);
    rd(6'h04, 8'h0C, "R4 tx enabled");
    wr(6'h08, 8'h0C);
    rd(6'h04, 8'h0C, "R4 reserved code no effect");
    wr(6'h08, 8'h08);
    rd(6'h04, 8'h08, "R4 tx disabled");

    // R5 receiver enable field
    wr(6'h08, 8'h01);
    check("R5 rx enabled", rx_en, 1'b1);
    wr(6'h08, 8'h03);
    check("R5 reserved code no effect", rx_en, 1'b1);
    wr(6'h08, 8'h02);
    check("R5 rx disabled", rx_en, 1'b0);

    // R6 transmit holding while disabled, then handshake
    wr(6'h0C, 8'hA1);
    rd(6'h04, 8'h00, "R6 empty cleared");
    check("R6 no offer while disabled", tx_valid, 1'b0);
    wr(6'h08, 8'h04);
    check("R6 offer once enabled", tx_valid, 1'b1);
    check("R6 offered byte", tx_data, 8'hA1);
    rd(6'h04, 8'h04, "R6 empty clear while pending");
    tx_exp_q.push_back(8'hA1);
    @(negedge clk); tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    check("R6 offer dropped after beat", tx_valid, 1'b0);
    rd(6'h04, 8'h0C, "R6 empty set after beat");

    // R7 write coinciding with handshake
    @(negedge clk); tx_ready = 1'b1;
    tx_exp_q.push_back(8'hB2);
    tx_exp_q.push_back(8'hC3);
    wr(6'h0C, 8'hB2);
    wr(6'h0C, 8'hC3);
    check("R7 second byte pending", tx_valid, 1'b1);
    check("R7 second byte data", tx_data, 8'hC3);
    @(posedge clk); #1 tx_ready = 1'b0;
    rd(6'h04, 8'h0C, "R7 empty after both beats");
    check("R7 beat count", tx_beats, 3);

    // R9 transmitter reset
    wr(6'h0C, 8'hD4);
    check("R9 pending before reset", tx_valid, 1'b1);
    wr(6'h08, 8'h30);
    check("R9 offer dropped", tx_valid, 1'b0);
    rd(6'h04, 8'h08, "R9 status after tx reset");
    wr(6'h08, 8'h34);
    rd(6'h04, 8'h0C, "R9 reset then enable");
    check("R9 nothing pending", tx_valid, 1'b0);

    // R8 receiver reset
    wr(6'h08, 8'h01);
    wr(6'h08, 8'h20);
    check("R8 rx disabled by reset", rx_en, 1'b0);
    check("R8 one flush pulse", flushes, 1);
    wr(6'h08, 8'h21);
    check("R8 reset then enable", rx_en, 1'b1);
    check("R8 second flush pulse", flushes, 2);

    // R11 status from receive path
    @(negedge clk); rx_empty = 1'b0; rx_full = 1'b1; rx_err = 4'hA; rx_data = 8'h5E;
    rd(6'h04, 8'hAF, "R11 status mirrors fifo and errors");

    // R10 receive data read
    rd(6'h0C, 8'h5E, "R10 read head byte");
    check("R10 one pop", pops, 1);
    @(negedge clk); rx_empty = 1'b1; rx_full = 1'b0; rx_err = 4'h0;
    rd(6'h0C, 8'h00, "R10 empty read zero");
    check("R10 no pop when empty", pops, 1);

    // R12 interrupt flags
    @(negedge clk); rx_empty = 1'b0;
    rd(6'h14, 8'h03, "R12 flag1 from data ready");
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h40);
    rd(6'h14, 8'h01, "R12 flag1 from full, not full");
    @(negedge clk); rx_full = 1'b1;
    rd(6'h14, 8'h03, "R12 flag1 from full");
    @(negedge clk); rx_break = 1'b1;
    @(posedge clk); #1 rx_break = 1'b0;
    rd(6'h14, 8'h07, "R12 break flag set");
    wr(6'h08, 8'h50);
    rd(6'h14, 8'h03, "R12 break flag cleared");
    @(negedge clk);
    rx_break = 1'b1; req = 1'b1; we = 1'b1; addr = 6'h08; wdata = 8'h50;
    @(posedge clk); #1 rx_break = 1'b0; req = 1'b0; we = 1'b0;
    rd(6'h14, 8'h07, "R12 set wins over clear");

    // R13 mask and registered irq
    wr(6'h14, 8'h04);
    check("R13 irq lags mask by one clock", irq, 1'b0);
    @(posedge clk); #1;
    check("R13 irq raised", irq, 1'b1);
    wr(6'h08, 8'h50);
    check("R13 irq still high one clock", irq, 1'b1);
    @(posedge clk); #1;
    check("R13 irq dropped", irq, 1'b0);
    wr(6'h14, 8'h00);

    repeat (2) @(posedge clk);
    check("R6 tx queue drained", tx_exp_q.size(), 0);
    finish_run();
  end
endmodule